// File: doc/BRIEF.md
# Watchdog Second-Expiry Recovery Sequencer

This block sits beside a hardware watchdog and takes over once the watchdog has expired twice in a row without being serviced. On that second expiry it raises a sticky status flag. While the flag is up, it emits a periodic one-cycle alert strobe that a message engine turns into alert packets. Only a software write-one-to-clear stops the alerts. The alerts keep running through every recovery step the block drives.

After the second expiry the sequencer handles three kinds of user action:

- A power-button override sends the system to soft-off.
- A later button press requests a wake to the working state.
- A reset request starts a system reset attempt. It arrives either as a low pulse on the power-good input or as a command from the management slave interface.

Each wake or reset attempt is judged by a boot-ok handshake that must arrive within a programmable window. On success the sequencer re-arms and watches the watchdog again. On failure it latches and waits for an outside reset request. It never retries on its own.

The current sequencer state is presented on `state_o` so software can read it. The soft-off, wake and reset requests are level outputs that stay high for as long as the matching state is held.

Top module: `wdt_recovery_ctrl`

## Requirements
- R1: After reset the state output reads 0 (idle), the status flag is 0, and the alert strobe, soft-off, wake and reset outputs are all 0.
- R2: A watchdog expiry in idle moves the state to 1 (first-expired). A further expiry in state 1 moves it to 2 (alerting) and sets the status flag on the same clock edge.
- R3: The status flag is sticky and is cleared only by a one-cycle `sts_clr_i` pulse, with effect on the next edge. If the clear pulse and a second-expiry event fall in the same cycle, the flag stays set.
- R4: While the status flag is 1, `alert_strobe_o` pulses for one cycle every `alert_interval_i` cycles. The first pulse comes in the `alert_interval_i`-th cycle in which the flag reads 1. While the flag is 0 there is no pulse.
- R5: In states 2 (alerting), 3 (soft-off) and 6 (latched-failed), a reset request moves the state to 4 (reset-pending), with `sys_reset_o` high while there. A reset request is a high-to-low transition on `pwrgood_i` or a pulse on `mgmt_rst_cmd_i`. A third or later expiry in state 2 leaves the state unchanged, so a reset request is honoured both before and after it.
- R6: A power-button override in state 2 moves the state to 3 (soft-off), with `soft_off_o` high while there. The status flag is unaffected.
- R7: A button press in state 3 moves the state to 5 (wake-pending), with `wake_req_o` high while there.
- R8: In state 4 or 5, `boot_ok_i` high during any of the first `boot_window_i` cycles of the attempt returns the state to 0 (idle). This includes the last of those cycles. The status flag and alerts carry on.
- R9: If `boot_ok_i` stays low for `boot_window_i` cycles of an attempt, the state becomes 6 (latched-failed). In state 6, expiries, overrides, button presses and `boot_ok_i` leave the state at 6. Only a reset request leaves it.
- R10: In states 0 and 1, reset requests, overrides and button presses leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdt_expire_i | input | 1 | One-cycle pulse per watchdog expiry |
| pwrgood_i | input | 1 | Power-good level; a falling edge requests a reset |
| mgmt_rst_cmd_i | input | 1 | One-cycle reset command from the management slave |
| pwrbtn_ovr_i | input | 1 | One-cycle power-button override |
| pwrbtn_press_i | input | 1 | One-cycle power-button press |
| boot_ok_i | input | 1 | Boot-ok handshake from the power sequencer |
| sts_clr_i | input | 1 | Write-one-to-clear strobe for the status flag |
| alert_interval_i | input | CNT_W | Alert period in cycles (0 treated as 1) |
| boot_window_i | input | CNT_W | Attempt window in cycles (0 treated as 1) |
| alert_strobe_o | output | 1 | One-cycle alert pulse |
| second_to_sts_o | output | 1 | Sticky second-expiry status flag |
| soft_off_o | output | 1 | Soft-off request, high in state 3 |
| wake_req_o | output | 1 | Wake request, high in state 5 |
| sys_reset_o | output | 1 | System reset request, high in state 4 |
| state_o | output | 3 | Current sequencer state |

## Verification
The bench builds the block with CNT_W = 8 and drives an alert interval of 4 and a boot window of 3. With these values several pacing periods fit into a few dozen cycles. A window expiry and a boot-ok landing on the window's last cycle can both be reached in three steps. These short values also let the bench show that the alert cadence carries on undisturbed across a reset attempt and the latched-failed state.

// File: rtl/wdt_recovery_pkg.sv
package wdt_recovery_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_FIRST   = 3'd1,
        ST_ALERT   = 3'd2,
        ST_SOFTOFF = 3'd3,
        ST_RSTPEND = 3'd4,
        ST_WAKEPND = 3'd5,
        ST_FAILED  = 3'd6
    } seq_state_t;

endpackage

// File: rtl/wdt_alert_pacer.sv
module wdt_alert_pacer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [CNT_W-1:0] interval_i,
    output logic             strobe_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last     = (interval_i == '0) ? '0 : interval_i - ONE;
        strobe_o = active_i && (cnt_q >= last);
        cnt_d    = cnt_q;
        if (!active_i || cnt_q >= last) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdt_attempt_timer.sv
module wdt_attempt_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] window_i,
    output logic             expired_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last      = (window_i == '0) ? '0 : window_i - ONE;
        expired_o = run_i && (cnt_q >= last);
        cnt_d     = '0;
        if (run_i && cnt_q < last) cnt_d = cnt_q + ONE;
        else if (run_i)            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdt_sticky_status.sv
module wdt_sticky_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic sts_o
);
    logic sts_d, sts_q;

    always_comb begin
        sts_d = (sts_q && !clr_i) || set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= 1'b0;
        else        sts_q <= sts_d;
    end

    assign sts_o = sts_q;
endmodule

// File: rtl/wdt_recovery_ctrl.sv
module wdt_recovery_ctrl
    import wdt_recovery_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_expire_i,
    input  logic             pwrgood_i,
    input  logic             mgmt_rst_cmd_i,
    input  logic             pwrbtn_ovr_i,
    input  logic             pwrbtn_press_i,
    input  logic             boot_ok_i,
    input  logic             sts_clr_i,
    input  logic [CNT_W-1:0] alert_interval_i,
    input  logic [CNT_W-1:0] boot_window_i,
    output logic             alert_strobe_o,
    output logic             second_to_sts_o,
    output logic             soft_off_o,
    output logic             wake_req_o,
    output logic             sys_reset_o,
    output logic [2:0]       state_o
);
    typedef struct packed {
        seq_state_t st;
        logic       pg;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  rst_req;
    logic  second_evt;
    logic  attempt_run;
    logic  window_over;

    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.pg  = pwrgood_i;
        rst_req    = (ctrl_q.pg && !pwrgood_i) || mgmt_rst_cmd_i;
        second_evt = (ctrl_q.st == ST_FIRST) && wdt_expire_i;

        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (wdt_expire_i) ctrl_d.st = ST_FIRST;
            end
            ST_FIRST: begin
                if (wdt_expire_i) ctrl_d.st = ST_ALERT;
            end
            ST_ALERT: begin
                if (rst_req)           ctrl_d.st = ST_RSTPEND;
                else if (pwrbtn_ovr_i) ctrl_d.st = ST_SOFTOFF;
            end
            ST_SOFTOFF: begin
                if (rst_req)             ctrl_d.st = ST_RSTPEND;
                else if (pwrbtn_press_i) ctrl_d.st = ST_WAKEPND;
            end
            ST_RSTPEND, ST_WAKEPND: begin
                if (boot_ok_i)        ctrl_d.st = ST_IDLE;
                else if (window_over) ctrl_d.st = ST_FAILED;
            end
            ST_FAILED: begin
                if (rst_req) ctrl_d.st = ST_RSTPEND;
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.st <= ST_IDLE;
            ctrl_q.pg <= 1'b1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign attempt_run = (ctrl_q.st == ST_RSTPEND) || (ctrl_q.st == ST_WAKEPND);

    wdt_sticky_status u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (second_evt),
        .clr_i (sts_clr_i),
        .sts_o (second_to_sts_o)
    );

    wdt_alert_pacer #(.CNT_W(CNT_W)) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (second_to_sts_o),
        .interval_i (alert_interval_i),
        .strobe_o   (alert_strobe_o)
    );

    wdt_attempt_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (attempt_run),
        .window_i  (boot_window_i),
        .expired_o (window_over)
    );

    assign soft_off_o  = (ctrl_q.st == ST_SOFTOFF);
    assign wake_req_o  = (ctrl_q.st == ST_WAKEPND);
    assign sys_reset_o = (ctrl_q.st == ST_RSTPEND);
    assign state_o     = ctrl_q.st;
endmodule

// File: rtl/wdt_recovery_chk.sv
module wdt_recovery_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wdt_expire_i,
    input logic       mgmt_rst_cmd_i,
    input logic       pwrbtn_ovr_i,
    input logic       pwrbtn_press_i,
    input logic       boot_ok_i,
    input logic       sts_clr_i,
    input logic       alert_strobe_o,
    input logic       second_to_sts_o,
    input logic       soft_off_o,
    input logic       wake_req_o,
    input logic       sys_reset_o,
    input logic [2:0] state_o
);
    p_second_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && wdt_expire_i) |=> (state_o == 3'd2 && second_to_sts_o));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (second_to_sts_o && !sts_clr_i) |=> second_to_sts_o);

    p_strobe_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alert_strobe_o |-> second_to_sts_o);

    p_mgmt_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && mgmt_rst_cmd_i) |=> (state_o == 3'd4 && sys_reset_o));

    p_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && pwrbtn_ovr_i) |=> (state_o == 3'd3 || state_o == 3'd4));

    p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && pwrbtn_press_i && !mgmt_rst_cmd_i) |=> (state_o == 3'd5 || state_o == 3'd4));

    p_boot_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd4 || state_o == 3'd5) && boot_ok_i) |=> (state_o == 3'd0));

    p_failed_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd6) |=> (state_o == 3'd6 || state_o == 3'd4));

    p_early_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && !wdt_expire_i) |=> (state_o == 3'd0));

    p_req_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({soft_off_o, wake_req_o, sys_reset_o}));
endmodule

bind wdt_recovery_ctrl wdt_recovery_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wdt_expire_i    (wdt_expire_i),
    .mgmt_rst_cmd_i  (mgmt_rst_cmd_i),
    .pwrbtn_ovr_i    (pwrbtn_ovr_i),
    .pwrbtn_press_i  (pwrbtn_press_i),
    .boot_ok_i       (boot_ok_i),
    .sts_clr_i       (sts_clr_i),
    .alert_strobe_o  (alert_strobe_o),
    .second_to_sts_o (second_to_sts_o),
    .soft_off_o      (soft_off_o),
    .wake_req_o      (wake_req_o),
    .sys_reset_o     (sys_reset_o),
    .state_o         (state_o)
);

// File: tb/wdt_recovery_ctrl_test.sv
module wdt_recovery_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wdt_expire_i = 1'b0, pwrgood_i = 1'b1, mgmt_rst_cmd_i = 1'b0;
    logic pwrbtn_ovr_i = 1'b0, pwrbtn_press_i = 1'b0, boot_ok_i = 1'b0, sts_clr_i = 1'b0;
    logic [CNT_W-1:0] alert_interval_i = 8'd4;
    logic [CNT_W-1:0] boot_window_i    = 8'd3;
    logic alert_strobe_o, second_to_sts_o, soft_off_o, wake_req_o, sys_reset_o;
    logic [2:0] state_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_recovery_ctrl #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .wdt_expire_i(wdt_expire_i), .pwrgood_i(pwrgood_i),
        .mgmt_rst_cmd_i(mgmt_rst_cmd_i), .pwrbtn_ovr_i(pwrbtn_ovr_i),
        .pwrbtn_press_i(pwrbtn_press_i), .boot_ok_i(boot_ok_i), .sts_clr_i(sts_clr_i),
        .alert_interval_i(alert_interval_i), .boot_window_i(boot_window_i),
        .alert_strobe_o(alert_strobe_o), .second_to_sts_o(second_to_sts_o),
        .soft_off_o(soft_off_o), .wake_req_o(wake_req_o), .sys_reset_o(sys_reset_o),
        .state_o(state_o)
    );

    // Vector: {expire, mgmt, ovr, press, boot_ok, clr, exp_state[2:0], exp_sts}
    localparam logic [9:0] VEC [9] = '{
        {6'b100000, 3'd1, 1'b0},   // R2 first expiry
        {6'b000000, 3'd1, 1'b0},   // R2 hold
        {6'b010000, 3'd1, 1'b0},   // R10 mgmt reset ignored in state 1
        {6'b100000, 3'd2, 1'b1},   // R2 second expiry sets flag
        {6'b100000, 3'd2, 1'b1},   // R5 third expiry leaves state
        {6'b001000, 3'd3, 1'b1},   // R6 override -> soft-off
        {6'b000100, 3'd5, 1'b1},   // R7 press -> wake pending
        {6'b000010, 3'd0, 1'b1},   // R8 boot ok -> idle, flag kept
        {6'b000001, 3'd0, 1'b0}    // R3 clear
    };

    task automatic chk(input string rq, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, expv);
        end
    endtask

    // Apply inputs for one cycle; return at the following negedge.
    task automatic cyc(input logic e, input logic m, input logic o, input logic p,
                       input logic b, input logic c, input logic g);
        wdt_expire_i = e; mgmt_rst_cmd_i = m; pwrbtn_ovr_i = o; pwrbtn_press_i = p;
        boot_ok_i = b; sts_clr_i = c; pwrgood_i = g;
        @(negedge clk);
        wdt_expire_i = 0; mgmt_rst_cmd_i = 0; pwrbtn_ovr_i = 0; pwrbtn_press_i = 0;
        boot_ok_i = 0; sts_clr_i = 0; pwrgood_i = 1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int first_idx;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 state", state_o, 0);
        chk("R1 flag", second_to_sts_o, 0);
        chk("R1 outputs", {alert_strobe_o, soft_off_o, wake_req_o, sys_reset_o}, 0);

        for (int i = 0; i < 9; i++) begin
            cyc(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], 1'b1);
            chk($sformatf("R2/R3/R5-R8/R10 vec%0d state", i), state_o, int'(VEC[i][3:1]));
            chk($sformatf("R2/R3/R8 vec%0d flag", i), second_to_sts_o, int'(VEC[i][0]));
        end

        // R4 pacing: strobes at flag-high cycle indices 3, 7, 11
        cyc(1, 0, 0, 0, 0, 0, 1);
        cyc(1, 0, 0, 0, 0, 0, 1);
        chk("R2 alerting", state_o, 2);
        cnt = 0; first_idx = -1;
        for (int k = 0; k < 12; k++) begin
            if (k > 0) cyc(0, 0, 0, 0, 0, 0, 1);
            if (alert_strobe_o) begin
                cnt++;
                if (first_idx < 0) first_idx = k;
            end
        end
        chk("R4 strobe count", cnt, 3);
        chk("R4 first strobe index", first_idx, 3);

        // R5 power-good low pulse, R9 window expiry; alerts continue
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            cyc(0, 0, 0, 0, 0, 0, (k == 0) ? 1'b0 : 1'b1);
            chk($sformatf("R5/R9 pg attempt step%0d", k), state_o, (k < 3) ? 4 : 6);
            if (k == 0) chk("R5 sys_reset_o", sys_reset_o, 1);
            if (alert_strobe_o) cnt++;
        end
        chk("R4 strobes across attempt", cnt, 2);

        // R9 latched-failed ignores these
        cyc(1, 0, 0, 0, 0, 0, 1); chk("R9 expiry ignored", state_o, 6);
        cyc(0, 0, 1, 0, 0, 0, 1); chk("R9 override ignored", state_o, 6);
        cyc(0, 0, 0, 1, 0, 0, 1); chk("R9 press ignored", state_o, 6);
        cyc(0, 0, 0, 0, 1, 0, 1); chk("R9 boot_ok ignored", state_o, 6);
        chk("R9 no requests", {soft_off_o, wake_req_o, sys_reset_o}, 0);

        // R5 mgmt leaves failed, R8 success
        cyc(0, 1, 0, 0, 0, 0, 1); chk("R5 mgmt from failed", state_o, 4);
        cyc(0, 0, 0, 0, 1, 0, 1); chk("R8 success", state_o, 0);
        chk("R8 flag kept", second_to_sts_o, 1);

        // R8 boot_ok on last window cycle
        cyc(1, 0, 0, 0, 0, 0, 1);
        cyc(1, 0, 0, 0, 0, 0, 1);
        cyc(0, 1, 0, 0, 0, 0, 1); chk("R8 edge step0", state_o, 4);
        cyc(0, 0, 0, 0, 0, 0, 1); chk("R8 edge step1", state_o, 4);
        cyc(0, 0, 0, 0, 0, 0, 1); chk("R8 edge step2", state_o, 4);
        cyc(0, 0, 0, 0, 1, 0, 1); chk("R8 last-cycle boot ok", state_o, 0);

        // R3 clear, R4 silence
        cyc(0, 0, 0, 0, 0, 1, 1); chk("R3 cleared", second_to_sts_o, 0);
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            cyc(0, 0, 0, 0, 0, 0, 1);
            if (alert_strobe_o) cnt++;
        end
        chk("R4 no strobe when clear", cnt, 0);

        // R3 set beats clear
        cyc(1, 0, 0, 0, 0, 0, 1);
        cyc(1, 0, 0, 0, 0, 1, 1); chk("R3 set wins", second_to_sts_o, 1);
        cyc(0, 0, 0, 0, 0, 1, 1); chk("R3 clear alone", second_to_sts_o, 0);
        chk("R3 state kept", state_o, 2);

        // R6/R7 then wake failure R9
        cyc(0, 0, 1, 0, 0, 0, 1); chk("R6 soft-off", soft_off_o, 1);
        cyc(0, 0, 0, 1, 0, 0, 1); chk("R7 wake req", wake_req_o, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 1); chk("R9 wake still pending", state_o, 5);
        cyc(0, 0, 0, 0, 0, 0, 1); chk("R9 wake failed", state_o, 6);

        finish_run();
    end
endmodule